// File: doc/BRIEF.md
# Register Write-Protection Unlock Controller

This block keeps a group of system control registers safe from stray writes. The registers start out locked. Software opens them by writing three key bytes, in a fixed order, to one unlock register on a simple register bus. Once the last key byte lands, a status bit goes to 1. From then on, every write that the surrounding fabric marks as aimed at a protected register receives a write-enable qualifier. While the status bit is 0, the qualifier stays low, so protected writes are silently dropped.

The unlock register serves two purposes. A write to it carries a key byte in the low eight bits of the write data. A read of it returns the lock status in bit 0, and the key is never read back. Writes to any other address between key bytes are ignored by the sequence detector. A wrong byte sent to the unlock register sends the detector back to its start, and if the lock is open, the same wrong byte closes it. The protected registers themselves live outside the block. They take `prot_wr_en` as the write enable.

Top module: `wpl_lock_ctrl`

## Requirements
- R1: After a synchronous reset, `unlocked` is 0 and `bus_rdata` is 0.
- R2: The key sequence 0x59, 0x16, 0x88 must be written in that order to address `UNLOCK_ADDR`. It sets `unlocked` to 1 on the clock edge that takes the third write.
- R3: While `unlocked` is 0, `prot_wr_en` is 0 for every write. While `unlocked` is 1, `prot_wr_en` equals `bus_we & prot_hit` in the same cycle.
- R4: A read at `UNLOCK_ADDR` returns the lock status in bit 0, with all higher bits 0. A read at any other address returns 0. `bus_rdata` is registered and appears one edge after the address, showing the status held before that edge.
- R5: A byte written to the unlock register that is not the next expected key returns the detector to its start state.
- R6: A wrong byte that equals the first key (0x59) restarts the detector at the second step instead of the first.
- R7: While unlocked, a write to the unlock register whose byte is not the next expected key clears `unlocked` on that edge.
- R8: Writes to addresses other than `UNLOCK_ADDR` neither advance nor break the key sequence, and they do not change `unlocked`.
- R9: Only bits [7:0] of `bus_wdata` are compared against the key. The upper bits have no effect.
- R10: Writing the complete key sequence again while unlocked keeps `unlocked` at 1 throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Register bus address |
| bus_wdata | input | DW | Register bus write data; key byte in bits [7:0] |
| bus_we | input | 1 | Write strobe, one cycle per write |
| prot_hit | input | 1 | High when the current address is a protected register |
| bus_rdata | output | DW | Registered read data; lock status in bit 0 at the unlock address |
| prot_wr_en | output | 1 | Qualified write enable for the protected registers |
| unlocked | output | 1 | Lock status, 1 when protected writes are accepted |

## Verification
Three results have three different timings, and the checks follow each one. `prot_wr_en` is combinational in the cycle of the write, so it is sampled 1 ns after the inputs are driven and before the clock edge. `unlocked` changes on the edge that takes the deciding key write, so it is sampled just after that edge. `bus_rdata` is registered from the address, so it is sampled after the edge that follows the address and compared with the status held before that edge. The first and second key positions are each swept over all 256 byte values, with random-looking upper data bits. The expected status is computed in the bench from which byte completes the sequence.

// File: rtl/wpl_pkg.sv
package wpl_pkg;
  localparam int unsigned KEY_W = 8;
  typedef logic [KEY_W-1:0] key_t;
endpackage

// File: rtl/wpl_seq.sv
module wpl_seq
  import wpl_pkg::*;
#(
  parameter int unsigned NKEYS = 3,
  parameter logic [NKEYS*KEY_W-1:0] KEYS = 24'h88_16_59
) (
  input  logic clk,
  input  logic rst,
  input  logic key_wr,
  input  key_t key_byte,
  output logic seq_done,
  output logic seq_miss
);
  localparam int unsigned SW = (NKEYS > 2) ? $clog2(NKEYS) : 1;
  localparam logic [SW-1:0] LAST = SW'(NKEYS - 1);

  logic [SW-1:0]    step;
  logic [NKEYS-1:0] hit_vec;
  logic             exp_hit;

  for (genvar i = 0; i < NKEYS; i++) begin : g_cmp
    assign hit_vec[i] = (key_byte == KEYS[i*KEY_W +: KEY_W]);
  end

  always_comb begin
    exp_hit = 1'b0;
    for (int i = 0; i < NKEYS; i++) begin
      if (step == SW'(i)) exp_hit = hit_vec[i];
    end
  end

  assign seq_done = key_wr && exp_hit && (step == LAST);
  assign seq_miss = key_wr && !exp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (key_wr) begin
      if (exp_hit) begin
        step <= (step == LAST) ? '0 : step + SW'(1);
      end else if (hit_vec[0]) begin
        step <= SW'(1);
      end else begin
        step <= '0;
      end
    end
  end
endmodule

// File: rtl/wpl_lock_state.sv
module wpl_lock_state (
  input  logic clk,
  input  logic rst,
  input  logic seq_done,
  input  logic seq_miss,
  output logic unlocked
);
  always_ff @(posedge clk) begin
    if (rst)           unlocked <= 1'b0;
    else if (seq_done) unlocked <= 1'b1;
    else if (seq_miss) unlocked <= 1'b0;
  end
endmodule

// File: rtl/wpl_gate.sv
module wpl_gate #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] UNLOCK_ADDR = 12'h100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic          prot_hit,
  input  logic          unlocked,
  output logic          key_wr,
  output logic          prot_wr_en,
  output logic [DW-1:0] bus_rdata
);
  logic at_unlock;

  assign at_unlock  = (bus_addr == UNLOCK_ADDR);
  assign key_wr     = bus_we && at_unlock;
  assign prot_wr_en = bus_we && prot_hit && unlocked;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= at_unlock ? DW'(unlocked) : '0;
  end
endmodule

// File: rtl/wpl_lock_ctrl.sv
module wpl_lock_ctrl
  import wpl_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] UNLOCK_ADDR = 12'h100,
  parameter int unsigned NKEYS = 3,
  parameter logic [NKEYS*KEY_W-1:0] KEYS = 24'h88_16_59
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          prot_hit,
  output logic [DW-1:0] bus_rdata,
  output logic          prot_wr_en,
  output logic          unlocked
);
  logic key_wr;
  logic seq_done;
  logic seq_miss;
  logic unused_hi;

  assign unused_hi = ^bus_wdata[DW-1:KEY_W];

  wpl_gate #(.AW(AW), .DW(DW), .UNLOCK_ADDR(UNLOCK_ADDR)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .prot_hit   (prot_hit),
    .unlocked   (unlocked),
    .key_wr     (key_wr),
    .prot_wr_en (prot_wr_en),
    .bus_rdata  (bus_rdata)
  );

  wpl_seq #(.NKEYS(NKEYS), .KEYS(KEYS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .key_byte (bus_wdata[KEY_W-1:0]),
    .seq_done (seq_done),
    .seq_miss (seq_miss)
  );

  wpl_lock_state u_lock (
    .clk      (clk),
    .rst      (rst),
    .seq_done (seq_done),
    .seq_miss (seq_miss),
    .unlocked (unlocked)
  );
endmodule

// File: rtl/wpl_lock_chk.sv
module wpl_lock_chk #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] UNLOCK_ADDR = 12'h100
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic          prot_hit,
  input logic [DW-1:0] bus_rdata,
  input logic          prot_wr_en,
  input logic          unlocked,
  input logic          key_wr,
  input logic          seq_done,
  input logic          seq_miss
);
  assert_locked_no_wr_R3: assert property (@(posedge clk) disable iff (rst)
    !unlocked |-> !prot_wr_en);

  assert_open_wr_R3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && bus_we && prot_hit) |-> prot_wr_en);

  assert_done_opens_R2: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> unlocked);

  assert_miss_closes_R7: assert property (@(posedge clk) disable iff (rst)
    seq_miss |=> !unlocked);

  assert_other_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(unlocked));

  assert_rd_hi_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata >> 1) == '0);

  assert_rd_status_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == UNLOCK_ADDR) |=> (bus_rdata[0] == $past(unlocked)));
endmodule

bind wpl_lock_ctrl wpl_lock_chk #(.AW(AW), .DW(DW), .UNLOCK_ADDR(UNLOCK_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .prot_hit   (prot_hit),
  .bus_rdata  (bus_rdata),
  .prot_wr_en (prot_wr_en),
  .unlocked   (unlocked),
  .key_wr     (key_wr),
  .seq_done   (seq_done),
  .seq_miss   (seq_miss)
);

// File: tb/wpl_lock_ctrl_tb.sv
`timescale 1ns/1ps
module wpl_lock_ctrl_tb;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] UA = 12'h100;
  localparam logic [AW-1:0] PA = 12'h024;
  localparam logic [AW-1:0] OA = 12'h030;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          prot_hit = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          prot_wr_en;
  logic          unlocked;
  logic [DW-1:0] shadow;

  int checks = 0;
  int fails = 0;
  logic pwe_seen;

  always #4 clk = ~clk;

  wpl_lock_ctrl #(.AW(AW), .DW(DW), .UNLOCK_ADDR(UA)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .prot_hit(prot_hit), .bus_rdata(bus_rdata),
    .prot_wr_en(prot_wr_en), .unlocked(unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) shadow <= '0;
    else if (prot_wr_en) shadow <= bus_wdata;
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic we, input logic hit);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we; prot_hit = hit;
    #1 pwe_seen = prot_wr_en;
    @(posedge clk);
    #1 bus_we = 1'b0; prot_hit = 1'b0;
  endtask

  task automatic key(input logic [7:0] b);
    access(UA, {24'h0, b}, 1'b1, 1'b0);
  endtask

  task automatic unlock_now();
    key(8'h59); key(8'h16); key(8'h88);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 status after reset", DW'(unlocked), 0);
    chk("R1 rdata after reset", bus_rdata, 0);

    // R3 locked protected write dropped
    access(PA, 32'hDEAD_BEEF, 1'b1, 1'b1);
    chk("R3 locked qualifier", DW'(pwe_seen), 0);
    chk("R3 locked write dropped", shadow, 0);
    access(UA, 32'h0, 1'b0, 1'b0);
    chk("R4 read locked status", bus_rdata, 0);

    // R2 sweep first key position over all bytes, upper bits noisy (R9)
    for (int b = 0; b < 256; b++) begin
      access(UA, {8'(b ^ 8'h3C), 8'(b), 8'(~b), 8'(b)}, 1'b1, 1'b0);
      access(UA, {24'hC3A5F0, 8'h16}, 1'b1, 1'b0);
      access(UA, {24'h5A0F1E, 8'h88}, 1'b1, 1'b0);
      chk("R2 R9 first-position sweep", DW'(unlocked), DW'(b == 8'h59));
      if (unlocked) key(8'h00);
    end

    // R5 R6 sweep second key position
    for (int b = 0; b < 256; b++) begin
      key(8'h59);
      access(UA, {8'(b), 16'hA55A, 8'(b)}, 1'b1, 1'b0);
      key(8'h88);
      chk("R5 R6 second-position sweep", DW'(unlocked), DW'(b == 8'h16));
      if (unlocked) key(8'h00);
    end

    // R5 broken third step
    key(8'h59); key(8'h16); key(8'h00); key(8'h88);
    chk("R5 broken sequence stays locked", DW'(unlocked), 0);
    // out of order
    key(8'h16); key(8'h59); key(8'h88);
    chk("R5 out-of-order stays locked", DW'(unlocked), 0);
    // R6 repeated first key
    key(8'h59); key(8'h59); key(8'h16); key(8'h88);
    chk("R6 repeated first key unlocks", DW'(unlocked), 1);
    key(8'h00);
    chk("R7 relock after wrong byte", DW'(unlocked), 0);

    // R8 interleaved writes elsewhere
    key(8'h59);
    access(OA, 32'h16, 1'b1, 1'b0);
    key(8'h16);
    access(PA, 32'h59, 1'b1, 1'b1);
    chk("R8 locked interleaved protected write dropped", shadow, 0);
    key(8'h88);
    chk("R8 interleaved sequence unlocks", DW'(unlocked), 1);
    access(OA, 32'h00, 1'b1, 1'b0);
    chk("R8 other-address write keeps status", DW'(unlocked), 1);

    // R3 unlocked writes
    access(PA, 32'h1234_5678, 1'b1, 1'b1);
    chk("R3 unlocked qualifier", DW'(pwe_seen), 1);
    chk("R3 unlocked write accepted", shadow, 32'h1234_5678);
    access(OA, 32'hFFFF_0000, 1'b1, 1'b0);
    chk("R3 no qualifier without match", DW'(pwe_seen), 0);
    chk("R3 shadow unchanged", shadow, 32'h1234_5678);

    // R4 readback
    access(UA, 32'h0, 1'b0, 1'b0);
    chk("R4 read open status", bus_rdata, 1);
    access(OA, 32'h0, 1'b0, 1'b0);
    chk("R4 other address reads zero", bus_rdata, 0);

    // R10 repeated full sequence while open
    key(8'h59);
    chk("R10 first key keeps open", DW'(unlocked), 1);
    key(8'h16);
    chk("R10 second key keeps open", DW'(unlocked), 1);
    key(8'h88);
    chk("R10 third key keeps open", DW'(unlocked), 1);

    // R7 out-of-step key byte relocks
    key(8'h16);
    chk("R7 out-of-step byte relocks", DW'(unlocked), 0);
    access(PA, 32'hAAAA_5555, 1'b1, 1'b1);
    chk("R7 relocked write dropped", shadow, 32'h1234_5678);

    // R1 reset again from open state
    unlock_now();
    chk("R2 unlock before reset", DW'(unlocked), 1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    chk("R1 reset relocks", DW'(unlocked), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule